// File: doc/BRIEF.md
# Microprogram Address Sequencer

This block decides which control-store word a microprogrammed control unit reads next. It holds the control address register, which drives the control memory address, and a one-deep subroutine return register. On every clock edge it reads three fields of the microinstruction now being executed: a condition select, a branch kind and a branch target. It also reads three status bits from the datapath and the opcode of the machine instruction being decoded. From these it loads the address register from one of four sources: the incremented address, the branch target, the saved return address, or a routine slot derived from the opcode.

The condition select chooses one of four tests. The first is a constant true, used for unconditional branches. The other three are the indirect-address bit of the fetched instruction, the accumulator sign bit, and an accumulator-is-zero flag. A small decode table turns the branch kind and the tested condition into a source select and a return-register load strobe. Opcode mapping places the routine for each machine instruction on a four-word boundary in the lower half of the control store. Reset points the sequencer at the start of the fetch routine.

Top module: `useq_top`

## Requirements
- R1: A synchronous active-high reset sets the address register to 64 and the return register to 0 on the next rising edge, whatever the other inputs are.
- R2: The condition select encodes 00 as constant true, 01 as the indirect bit, 10 as the accumulator sign bit and 11 as the accumulator-zero flag.
- R3: With branch kind 00 (jump) or 01 (call) and a true condition, the address register loads the branch target.
- R4: With branch kind 00 or 01 and a false condition, the address register loads its own value plus one.
- R5: With branch kind 01 and a true condition, the return register loads the current address plus one in the same edge.
- R6: The return register keeps its value for a jump, return, map or a call whose condition is false.
- R7: With branch kind 10 (return), the address register loads the return register contents, whatever the condition.
- R8: With branch kind 11 (map), the address register loads the 4-bit opcode in bits 5..2 with bits 6, 1 and 0 cleared, whatever the condition.
- R9: The incrementer wraps modulo 128, so address 127 plus one gives 0, both for the address register and for the saved return address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_sel | input | 2 | Condition select field of the current microinstruction |
| br_kind | input | 2 | Branch kind: 00 jump, 01 call, 10 return, 11 map |
| br_target | input | 7 | Branch target address field |
| ind_bit | input | 1 | Indirect-address bit of the fetched instruction |
| acc_sign | input | 1 | Accumulator sign bit |
| acc_zero | input | 1 | High when the accumulator is zero |
| opcode | input | 4 | Opcode of the machine instruction being decoded |
| car | output | 7 | Control address register, drives the control memory address |
| sbr | output | 7 | Subroutine return register |

## Verification
The bench builds the block with its default parameters: a 7-bit address, a 4-bit opcode, a mapping shift of 2 and a reset address of 64. With these values every address from 0 to 127 can be reached, so the wrap at the top of the store can be hit both by the address register and by a call placed at address 127. All sixteen opcode slots can also be checked against their 0xxxx00 addresses. Each status input is driven both high and low under its own select code. Calls, returns and maps are issued with the tested condition false, which shows that only calls and jumps depend on the test.

// File: rtl/useq_pkg.sv
package useq_pkg;

  // Branch kind carried in the microinstruction
  typedef enum logic [1:0] {
    BR_JUMP   = 2'b00,
    BR_CALL   = 2'b01,
    BR_RETURN = 2'b10,
    BR_MAP    = 2'b11
  } br_kind_t;

  // Source of the next control address
  typedef enum logic [1:0] {
    SRC_INC    = 2'b00,
    SRC_TARGET = 2'b01,
    SRC_RETURN = 2'b10,
    SRC_MAP    = 2'b11
  } nxt_src_t;

endpackage

// File: rtl/useq_cond_mux.sv
module useq_cond_mux #(
  parameter int SEL_W = 2
) (
  input  logic [SEL_W-1:0]         sel,
  input  logic [(1<<SEL_W)-1:1]    status,
  output logic                     cond
);
  localparam int NTAP = 1 << SEL_W;

  logic [NTAP-1:0] taps;

  // tap 0 is tied true for unconditional branches
  assign taps = {status, 1'b1};
  assign cond = taps[sel];

endmodule

// File: rtl/useq_input_logic.sv
module useq_input_logic
  import useq_pkg::*;
(
  input  br_kind_t br,
  input  logic     cond,
  output nxt_src_t src,
  output logic     link_load
);
  always_comb begin
    src       = SRC_INC;
    link_load = 1'b0;
    unique case (br)
      BR_JUMP: begin
        src = cond ? SRC_TARGET : SRC_INC;
      end
      BR_CALL: begin
        src       = cond ? SRC_TARGET : SRC_INC;
        link_load = cond;
      end
      BR_RETURN: src = SRC_RETURN;
      BR_MAP:    src = SRC_MAP;
      default:   src = SRC_INC;
    endcase
  end
endmodule

// File: rtl/useq_next_mux.sv
module useq_next_mux
  import useq_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int OP_W      = 4,
  parameter int MAP_SHIFT = 2
) (
  input  nxt_src_t            src,
  input  logic [ADDR_W-1:0]   cur,
  input  logic [ADDR_W-1:0]   target,
  input  logic [ADDR_W-1:0]   ret_addr,
  input  logic [OP_W-1:0]     opcode,
  output logic [ADDR_W-1:0]   incr,
  output logic [ADDR_W-1:0]   nxt
);
  localparam int MAP_TOP = OP_W + MAP_SHIFT;

  logic [ADDR_W-1:0] mapped;

  // modulo-2^ADDR_W incrementer
  assign incr = cur + ADDR_W'(1);

  generate
    if (MAP_TOP < ADDR_W) begin : g_map_pad
      assign mapped = {{(ADDR_W-MAP_TOP){1'b0}}, opcode, {MAP_SHIFT{1'b0}}};
    end else begin : g_map_trunc
      logic [MAP_TOP-1:0] wide;
      assign wide   = {opcode, {MAP_SHIFT{1'b0}}};
      assign mapped = wide[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (src)
      SRC_INC:    nxt = incr;
      SRC_TARGET: nxt = target;
      SRC_RETURN: nxt = ret_addr;
      SRC_MAP:    nxt = mapped;
      default:    nxt = incr;
    endcase
  end
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int OP_W       = 4,
  parameter int MAP_SHIFT  = 2,
  parameter int RESET_ADDR = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cond_sel,
  input  logic [1:0]        br_kind,
  input  logic [ADDR_W-1:0] br_target,
  input  logic              ind_bit,
  input  logic              acc_sign,
  input  logic              acc_zero,
  input  logic [OP_W-1:0]   opcode,
  output logic [ADDR_W-1:0] car,
  output logic [ADDR_W-1:0] sbr
);
  localparam logic [ADDR_W-1:0] START = ADDR_W'(RESET_ADDR);

  br_kind_t          br;
  nxt_src_t          src;
  logic              cond;
  logic              link_load;
  logic [ADDR_W-1:0] incr;
  logic [ADDR_W-1:0] nxt;

  assign br = br_kind_t'(br_kind);

  useq_cond_mux #(.SEL_W(2)) u_cond (
    .sel    (cond_sel),
    .status ({acc_zero, acc_sign, ind_bit}),
    .cond   (cond)
  );

  useq_input_logic u_inlog (
    .br        (br),
    .cond      (cond),
    .src       (src),
    .link_load (link_load)
  );

  useq_next_mux #(
    .ADDR_W    (ADDR_W),
    .OP_W      (OP_W),
    .MAP_SHIFT (MAP_SHIFT)
  ) u_next (
    .src      (src),
    .cur      (car),
    .target   (br_target),
    .ret_addr (sbr),
    .opcode   (opcode),
    .incr     (incr),
    .nxt      (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      car <= START;
      sbr <= '0;
    end else begin
      car <= nxt;
      if (link_load) sbr <= incr;
    end
  end

  // Assertions next to the registers they guard
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (car == START && sbr == '0)) else $error("reset state");          // R1
  AST_TAKEN_TARGET: assert property (@(posedge clk) disable iff (rst)
    ((br_kind == 2'b00 || br_kind == 2'b01) && cond) |=> car == $past(br_target)) else $error("taken"); // R3
  AST_NOT_TAKEN_STEP: assert property (@(posedge clk) disable iff (rst)
    ((br_kind == 2'b00 || br_kind == 2'b01) && !cond) |=> (car - $past(car)) == ADDR_W'(1)) else $error("step"); // R4
  AST_CALL_LINK: assert property (@(posedge clk) disable iff (rst)
    (br_kind == 2'b01 && cond) |=> (sbr - $past(car)) == ADDR_W'(1)) else $error("link"); // R5
  AST_LINK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(br_kind == 2'b01 && cond) |=> $stable(sbr)) else $error("hold");        // R6
  AST_RETURN_SRC: assert property (@(posedge clk) disable iff (rst)
    (br_kind == 2'b10) |=> car == $past(sbr)) else $error("return");          // R7
  AST_MAP_SLOT: assert property (@(posedge clk) disable iff (rst)
    (br_kind == 2'b11) |=> (car[MAP_SHIFT-1:0] == '0 &&
                            car[OP_W+MAP_SHIFT-1:MAP_SHIFT] == $past(opcode))) else $error("map"); // R8

endmodule

// File: tb/useq_top_bench.sv
module useq_top_bench;
  localparam int AW = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    cond_sel = '0;
  logic [1:0]    br_kind = '0;
  logic [AW-1:0] br_target = '0;
  logic          ind_bit = 1'b0;
  logic          acc_sign = 1'b0;
  logic          acc_zero = 1'b0;
  logic [3:0]    opcode = '0;
  logic [AW-1:0] car;
  logic [AW-1:0] sbr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  useq_top u_useq_top (
    .clk(clk), .rst(rst), .cond_sel(cond_sel), .br_kind(br_kind),
    .br_target(br_target), .ind_bit(ind_bit), .acc_sign(acc_sign),
    .acc_zero(acc_zero), .opcode(opcode), .car(car), .sbr(sbr)
  );

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive one microinstruction, let one edge pass, settle past the edge
  task automatic step(input logic [1:0] cd, input logic [1:0] br,
                      input logic [AW-1:0] ad, input logic [3:0] op);
    @(negedge clk);
    cond_sel = cd; br_kind = br; br_target = ad; opcode = op;
    @(posedge clk);
    #1;
  endtask

  task automatic go_to(input logic [AW-1:0] a);
    step(2'b00, 2'b00, a, 4'd0);
  endtask

  task automatic t_reset_state();
    repeat (2) @(posedge clk);
    #1;
    check("R1 car after reset", car, 7'd64);
    check("R1 sbr after reset", sbr, 7'd0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_jump();
    step(2'b00, 2'b00, 7'd10, 4'd0);
    check("R3 R2 unconditional jump", car, 7'd10);
    ind_bit = 1'b1;
    step(2'b01, 2'b00, 7'd20, 4'd0);
    check("R2 R3 indirect bit true", car, 7'd20);
    ind_bit = 1'b0;
    step(2'b01, 2'b00, 7'd30, 4'd0);
    check("R2 R4 indirect bit false", car, 7'd21);
    acc_sign = 1'b1;
    step(2'b10, 2'b00, 7'd50, 4'd0);
    check("R2 R3 sign true", car, 7'd50);
    acc_sign = 1'b0;
    step(2'b10, 2'b00, 7'd5, 4'd0);
    check("R2 R4 sign false", car, 7'd51);
    acc_zero = 1'b0;
    step(2'b11, 2'b00, 7'd5, 4'd0);
    check("R2 R4 zero false", car, 7'd52);
    acc_zero = 1'b1;
    step(2'b11, 2'b00, 7'd90, 4'd0);
    check("R2 R3 zero true", car, 7'd90);
    acc_zero = 1'b0;
    check("R6 sbr unchanged by jumps", sbr, 7'd0);
  endtask

  task automatic t_call_return();
    go_to(7'd40);
    step(2'b00, 2'b01, 7'd100, 4'd0);
    check("R3 call target", car, 7'd100);
    check("R5 call link", sbr, 7'd41);
    step(2'b10, 2'b01, 7'd5, 4'd0);
    check("R4 call not taken step", car, 7'd101);
    check("R6 call not taken keeps sbr", sbr, 7'd41);
    step(2'b10, 2'b10, 7'd9, 4'd0);
    check("R7 return with false condition", car, 7'd41);
    check("R6 return keeps sbr", sbr, 7'd41);
    go_to(7'd70);
    check("R6 jump keeps sbr", sbr, 7'd41);
  endtask

  task automatic t_map();
    for (int op = 0; op < 16; op++) begin
      step(2'b01, 2'b11, 7'd127, 4'(op));
      check("R8 opcode map", car, 7'(op * 4));
    end
    check("R6 map keeps sbr", sbr, 7'd41);
  endtask

  task automatic t_wrap();
    go_to(7'd126);
    step(2'b11, 2'b00, 7'd3, 4'd0);
    check("R9 step to 127", car, 7'd127);
    step(2'b11, 2'b00, 7'd3, 4'd0);
    check("R9 wrap to 0", car, 7'd0);
    go_to(7'd127);
    step(2'b00, 2'b01, 7'd12, 4'd0);
    check("R9 call at 127 target", car, 7'd12);
    check("R9 call at 127 links 0", sbr, 7'd0);
    step(2'b00, 2'b10, 7'd55, 4'd0);
    check("R7 return to wrapped link", car, 7'd0);
  endtask

  task automatic t_mid_reset();
    go_to(7'd33);
    step(2'b00, 2'b01, 7'd77, 4'd0);
    check("R5 link before reset", sbr, 7'd34);
    @(negedge clk);
    rst = 1'b1;
    cond_sel = 2'b00; br_kind = 2'b01; br_target = 7'd11;
    @(posedge clk);
    #1;
    check("R1 reset beats call car", car, 7'd64);
    check("R1 reset beats call sbr", sbr, 7'd0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    t_reset_state();
    t_jump();
    t_call_return();
    t_map();
    t_wrap();
    t_mid_reset();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule